// File: doc/BRIEF.md
# Staged Watchdog With Unlock Key

This block watches for missed service by counting expiry pulses from one of several external timers. Software sets three things in a configuration register: which timer input to follow, how many pulses make up one watchdog period, and which escalation outputs may fire. A start command then arms the counter. Each completed period moves the watchdog one stage further. The stages raise, in order, a local interrupt, a local fast interrupt, a remote interrupt, a debug-reset request and finally a power-on-reset request. Software services the watchdog by stopping it and starting it again, which returns it to stage zero.

A stop command takes effect only when a fixed key value was written to the unlock register just before it. Any write to the command register uses up the key. Once the watchdog is running with its local interrupt enabled, the configuration is frozen until the next reset. The timers themselves, reset sequencing and interrupt routing are outside this block.

Top module: `staged_wdog`

## Requirements
- R1: After reset all five outputs are low, the configuration reads as zero and the counter is stopped.
- R2: A write to address 0x0 stores data bits 16:0 as the configuration, and a read of address 0x0 returns them with all higher bits zero. Bits 3:0 select the timer input, bits 11:4 hold the period, bit 12 enables the local interrupt, bit 13 the fast interrupt, bit 14 the remote interrupt, bit 15 the debug reset and bit 16 the power-on reset. Reads of any other address return zero.
- R3: While running, each pulse on the selected `tick_in` bit advances a pulse count. The stage advances by one when the count reaches the period, and the count then restarts. A period of 0 counts as 1. Pulses on other inputs, and any pulses while the counter is stopped, have no effect.
- R4: An output is high while its enable bit is set and the stage has reached its level: `irq_local` at stage 1 or above, `irq_fast` at 2, `irq_remote` at 3, `dbg_rst_req` at 4 and `por_rst_req` at 5. The stage saturates at 5.
- R5: Writing address 0x8 with bit 0 set starts the counter and clears both the stage and the pulse count. A tick in the same cycle as the start is discarded.
- R6: Writing address 0x8 with bit 1 set stops the counter and clears the stage, but only if the value 0x0000C45A was written to address 0xC since the previous write to address 0x8. Without that key write, the command is ignored.
- R7: Any write to address 0x8 consumes the key. A write of any other value to address 0xC cancels a pending key.
- R8: A command with both bits set stops the counter when the key is valid. When the key is not valid, the same command acts as a start.
- R9: Once the counter runs with bit 12 of the configuration set, writes to address 0x0 are ignored until reset. This holds even after the counter is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write byte address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read byte address |
| rd_data | output | 32 | Register read data (combinational) |
| tick_in | input | 16 | Expiry pulses from the external timers |
| irq_local | output | 1 | Stage-1 local interrupt |
| irq_fast | output | 1 | Stage-2 local fast interrupt |
| irq_remote | output | 1 | Stage-3 remote interrupt |
| dbg_rst_req | output | 1 | Stage-4 debug-reset request |
| por_rst_req | output | 1 | Stage-5 power-on-reset request |

## Verification
A timer pulse on the selected input can arrive in the same cycle as a start command, so counting and restarting compete for the same registers. The bench raises the selected tick while a start write is held for one clock. It then expects two more pulses before the first stage appears, which shows that the coincident pulse was dropped. A behavioural reference model checks every output and the configuration readback on each clock, so the same race is also judged wherever it occurs in the other sequences.

// File: rtl/staged_wdog.sv
module staged_wdog #(
  parameter int NUM_TIMERS = 16,
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 32,
  parameter logic [31:0] UNLOCK_KEY = 32'h0000_C45A,
  parameter int LAST_STAGE = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [DATA_W-1:0]     rd_data,
  input  logic [NUM_TIMERS-1:0] tick_in,
  output logic                  irq_local,
  output logic                  irq_fast,
  output logic                  irq_remote,
  output logic                  dbg_rst_req,
  output logic                  por_rst_req
);
  localparam int CFG_W = 17;
  localparam int PER_W = 8;
  localparam int STG_W = $clog2(LAST_STAGE + 1);
  localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(4'h0);
  localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(4'h8);
  localparam logic [ADDR_W-1:0] A_KEY = ADDR_W'(4'hC);

  logic [CFG_W-1:0] cfg;
  logic             running, locked, key_ok;
  logic [STG_W-1:0] stage;
  logic [PER_W-1:0] pcnt;
  logic             tick_sel;

  wire cfg_wr   = wr_en && (wr_addr == A_CFG);
  wire cmd_wr   = wr_en && (wr_addr == A_CMD);
  wire key_wr   = wr_en && (wr_addr == A_KEY);
  wire do_stop  = cmd_wr && wr_data[1] && key_ok;
  wire do_start = cmd_wr && wr_data[0] && !do_stop;
  wire lock_now = locked || (running && cfg[12]);

  wire [PER_W-1:0] per_raw = cfg[11:4];
  wire [PER_W-1:0] per_eff = (per_raw == '0) ? PER_W'(1) : per_raw;
  wire             wrap    = ({1'b0, pcnt} + 1'b1) >= {1'b0, per_eff};

  always_comb begin
    tick_sel = 1'b0;
    for (int i = 0; i < NUM_TIMERS; i++)
      if (cfg[3:0] == 4'(i)) tick_sel = tick_in[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (cfg_wr && !lock_now) begin
      cfg <= wr_data[CFG_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      stage   <= '0;
      pcnt    <= '0;
    end else if (do_stop) begin
      running <= 1'b0;
      stage   <= '0;
      pcnt    <= '0;
    end else if (do_start) begin
      running <= 1'b1;
      stage   <= '0;
      pcnt    <= '0;
    end else if (running && tick_sel) begin
      if (wrap) begin
        pcnt <= '0;
        if (stage < STG_W'(LAST_STAGE)) stage <= stage + 1'b1;
      end else begin
        pcnt <= pcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b0;
      key_ok <= 1'b0;
    end else begin
      locked <= lock_now;
      if (cmd_wr)      key_ok <= 1'b0;
      else if (key_wr) key_ok <= (32'(wr_data) == UNLOCK_KEY);
    end
  end

  assign irq_local   = cfg[12] && (stage >= STG_W'(1));
  assign irq_fast    = cfg[13] && (stage >= STG_W'(2));
  assign irq_remote  = cfg[14] && (stage >= STG_W'(3));
  assign dbg_rst_req = cfg[15] && (stage >= STG_W'(4));
  assign por_rst_req = cfg[16] && (stage >= STG_W'(5));

  assign rd_data = (rd_addr == A_CFG) ? {{(DATA_W-CFG_W){1'b0}}, cfg} : '0;

  AST_STAGE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    stage <= STG_W'(LAST_STAGE)); // R4
  AST_STAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stage == $past(stage) || stage == $past(stage) + 1'b1 || stage == '0)); // R3
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && wr_data[0] && !wr_data[1]) |=> (running && stage == '0)); // R5
  AST_NO_KEY_NO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !key_ok && running) |=> running); // R6
  AST_STOPPED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (stage == '0)); // R6
  AST_KEY_USED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> !key_ok); // R7
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && cfg_wr) |=> $stable(cfg)); // R9
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked); // R9
endmodule

// File: tb/staged_wdog_test.sv
`timescale 1ns/1ps
module staged_wdog_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [15:0] tick_in = '0;
  logic        irq_local, irq_fast, irq_remote, dbg_rst_req, por_rst_req;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  staged_wdog uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tick_in(tick_in),
    .irq_local(irq_local), .irq_fast(irq_fast), .irq_remote(irq_remote),
    .dbg_rst_req(dbg_rst_req), .por_rst_req(por_rst_req)
  );

  always #2 clk = ~clk;

  // behavioural reference
  int   m_cfg, m_stage, m_cnt;
  bit   m_run, m_lock, m_key;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cfg = 0; m_stage = 0; m_cnt = 0; m_run = 0; m_lock = 0; m_key = 0;
    end else begin
      int  per;
      bit  lk, stop, start, tk;
      per   = (m_cfg >> 4) & 255;
      if (per == 0) per = 1;
      lk    = m_lock || (m_run && m_cfg[12]);
      stop  = wr_en && wr_addr == 8 && wr_data[1] && m_key;
      start = wr_en && wr_addr == 8 && wr_data[0] && !stop;
      tk    = tick_in[m_cfg & 15];
      if (stop) begin m_run = 0; m_stage = 0; m_cnt = 0; end
      else if (start) begin m_run = 1; m_stage = 0; m_cnt = 0; end
      else if (m_run && tk) begin
        m_cnt++;
        if (m_cnt >= per) begin m_cnt = 0; if (m_stage < 5) m_stage++; end
      end
      if (wr_en && wr_addr == 0 && !lk) m_cfg = wr_data & 32'h1FFFF;
      if (wr_en && wr_addr == 8) m_key = 0;
      else if (wr_en && wr_addr == 12) m_key = (wr_data == 32'h0000C45A);
      m_lock = lk;
    end
  end

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [4:0] outs();
    return {por_rst_req, dbg_rst_req, irq_remote, irq_fast, irq_local};
  endfunction

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      logic [4:0] e;
      e[0] = m_cfg[12] && m_stage >= 1;
      e[1] = m_cfg[13] && m_stage >= 2;
      e[2] = m_cfg[14] && m_stage >= 3;
      e[3] = m_cfg[15] && m_stage >= 4;
      e[4] = m_cfg[16] && m_stage >= 5;
      check("R4 model outputs", 32'(outs()), 32'(e));
      check("R2 model readback", rd_data, (rd_addr == 0) ? m_cfg : 0);
    end
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic wr(logic [3:0] a, logic [31:0] d, logic [15:0] t = '0);
    wr_en = 1; wr_addr = a; wr_data = d; tick_in = t;
    @(negedge clk);
    wr_en = 0; tick_in = '0;
  endtask

  task automatic tick(int idx, int n = 1);
    for (int i = 0; i < n; i++) begin
      tick_in = 16'(1) << idx;
      @(negedge clk);
      tick_in = '0;
      @(negedge clk);
    end
  endtask

  localparam logic [31:0] KEY = 32'h0000C45A;

  initial begin
    repeat (3) @(negedge clk);
    check("R1 outputs at reset", 32'(outs()), 0);
    check("R1 cfg at reset", rd_data, 0);
    rst_n = 1;
    @(negedge clk);

    wr(0, 32'hFFFF_FFFF);
    check("R2 upper bits masked", rd_data, 32'h1FFFF);
    wr(0, 32'h1F023);
    check("R2 cfg readback", rd_data, 32'h1F023);
    rd_addr = 4; #0.1;
    check("R2 other address reads zero", rd_data, 0);
    rd_addr = 0;

    tick(3, 4);
    check("R3 ticks ignored while stopped", 32'(outs()), 0);
    wr(8, 1);
    tick(5, 4);
    check("R3 unselected input ignored", 32'(outs()), 0);
    tick(3, 1);
    check("R3 one pulse of period 2", 32'(outs()), 0);
    tick(3, 1);
    check("R4 stage 1 local irq", 32'(outs()), 5'b00001);
    tick(3, 2);
    check("R4 stage 2 fast irq", 32'(outs()), 5'b00011);
    tick(3, 6);
    check("R4 stage 5 all outputs", 32'(outs()), 5'b11111);
    tick(3, 4);
    check("R4 stage saturates", 32'(outs()), 5'b11111);

    wr(8, 2);
    check("R6 stop without key ignored", 32'(outs()), 5'b11111);
    wr(0, 32'h00000);
    check("R9 cfg locked while running", rd_data, 32'h1F023);
    wr(12, KEY);
    wr(8, 2);
    check("R6 keyed stop clears stage", 32'(outs()), 0);
    tick(3, 4);
    check("R6 stopped ignores ticks", 32'(outs()), 0);
    wr(0, 32'h1F000);
    check("R9 lock persists after stop", rd_data, 32'h1F023);

    wr(8, 1, 16'h0008);
    tick(3, 1);
    check("R5 coincident tick dropped", 32'(outs()), 0);
    tick(3, 1);
    check("R5 stage 1 after two later ticks", 32'(outs()), 5'b00001);

    wr(12, KEY);
    wr(8, 0);
    wr(8, 2);
    tick(3, 2);
    check("R7 key consumed by empty command", 32'(outs()), 5'b00011);
    wr(12, KEY);
    wr(12, 32'h1234);
    wr(8, 2);
    tick(3, 2);
    check("R7 wrong value cancels key", 32'(outs()), 5'b00111);

    wr(12, KEY);
    wr(8, 3);
    check("R8 both bits with key stops", 32'(outs()), 0);
    tick(3, 2);
    check("R8 stays stopped", 32'(outs()), 0);
    wr(8, 3);
    tick(3, 2);
    check("R8 both bits without key starts", 32'(outs()), 5'b00001);

    rst_n = 0;
    @(negedge clk);
    check("R1 outputs after second reset", 32'(outs()), 0);
    rst_n = 1;
    @(negedge clk);
    wr(0, 32'h12000);
    wr(8, 1);
    tick(0, 2);
    check("R3 period zero counts as one", 32'(outs()), 5'b00010);
    wr(0, 32'h13000);
    check("R9 write accepted before lock", rd_data, 32'h13000);
    wr(0, 32'h1F000);
    check("R9 later write ignored", rd_data, 32'h13000);
    tick(0, 3);
    check("R4 stage 5 partial enables", 32'(outs()), 5'b10011);

    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule